// File: doc/BRIEF.md
# Flash Endurance Test Sequencer

This block drives repeated wear cycling on a span of flash blocks and keeps score of what goes wrong. A host sets an inclusive block span, a four-bit mask of enabled steps, a pass count and a data mode, then pulses `start`. For every pass the sequencer walks the span in ascending order. On each block it runs the enabled steps in a fixed order: erase, program, read-disturb, verify. It issues abstract commands to a lower-level flash command port and moves page data over separate write and read byte channels.

An erase is always followed by a status query. When that query reports a failure, the block is read back in full to confirm the failure against the erased value. Each page program is also followed by a status query. Read-disturb reads are drained and thrown away. Verify reads are compared byte by byte against a pattern regenerated on the fly. Five saturating counters record erase-status failures, confirmed erase failures, program-status failures, mismatched bytes and completed passes.

The controller is one state machine. Its states are `S_IDLE`, `S_PHASE`, `S_CMD`, `S_WDATA`, `S_STAT_CMD`, `S_STAT_WAIT`, `S_RDATA`, `S_NEXT_BLK` and `S_DONE`. Its transitions are:
- IDLE→PHASE on an accepted start, or IDLE→DONE when the run is empty.
- PHASE→CMD when the current step is enabled, and PHASE→NEXT_BLK once all steps are finished.
- CMD→STAT_CMD for an erase, CMD→WDATA for a program, and CMD→RDATA for any read.
- WDATA→STAT_CMD after the last byte, and STAT_CMD→STAT_WAIT once the command is accepted.
- STAT_WAIT→CMD to confirm an erase or to program the next page, and STAT_WAIT→PHASE otherwise.
- RDATA→CMD for the next page, and RDATA→PHASE after the last page.
- NEXT_BLK→PHASE for another block or pass, and NEXT_BLK→DONE after the final pass.
- DONE→IDLE.

Top module: `wear_cycler`

## Requirements
- R1: `start` is accepted only in the idle state. It latches all configuration inputs and raises `busy`, which stays high until the run ends. `done` is then high for exactly one cycle, with `busy` low. While a run is active, changes to the configuration inputs and further `start` pulses have no effect.
- R2: A start with a pass count of zero, or with first block greater than last block, ends in `done` without issuing any command.
- R3: Commands address only blocks from first to last inclusive. Each pass visits that span in ascending order. The pass counter rises by one after each full pass, and exactly the configured number of passes is run.
- R4: On each block the enabled steps run in the order erase (mask bit 0), program (bit 1), read-disturb (bit 2), verify (bit 3). Each page step covers pages 0 to PAGES-1 in ascending order.
- R5: Every erase is followed by a status command. A reported failure adds one to the erase-status counter.
- R6: After an erase-status failure, every page of that block is read. The confirmed-erase counter rises once for that erase if any byte differs from ERASED (default 0xFF), including a difference in the final byte of the final page.
- R7: A page program is one program command, then PAGE_BYTES write beats, then a status command. A reported failure adds one to the program-failure counter.
- R8: Read-disturb data is discarded and changes no counter.
- R9: During verify, each byte that differs from the regenerated pattern adds one to the mismatch counter.
- R10: With the random mode bit set, the pattern is the low byte of a 32-bit Galois LFSR. The LFSR shifts right and XORs mask 0x80200003 when the shifted-out bit is 1. It is loaded with the seed, or with 1 for a zero seed, at the start of each block's program step and again at the start of its verify step, and it steps once per byte. With the bit clear, every byte is the fixed pattern.
- R11: All counters clear on an accepted start and hold at all-ones instead of wrapping.
- R12: The command word has op encoding 0 erase, 1 program, 2 read, 3 status. Once `cmd_valid` or `wd_valid` is raised, it and its payload stay unchanged until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| cfg_first_blk | input | BLK_W | First block of the span |
| cfg_last_blk | input | BLK_W | Last block of the span |
| cfg_repeat | input | REP_W | Number of passes |
| cfg_ops | input | 4 | Step enables: bit0 erase, bit1 program, bit2 read-disturb, bit3 verify |
| cfg_rand | input | 1 | 1 = LFSR data, 0 = fixed byte |
| cfg_seed | input | SEED_W | LFSR seed |
| cfg_fixed | input | 8 | Fixed data byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_op | output | 2 | Operation code |
| cmd_blk | output | BLK_W | Block address |
| cmd_page | output | PAGE_W | Page address |
| wd_valid | output | 1 | Write byte offered |
| wd_ready | input | 1 | Write byte accepted |
| wd_data | output | 8 | Write byte |
| rd_valid | input | 1 | Read byte present |
| rd_data | input | 8 | Read byte |
| st_valid | input | 1 | Status response present |
| st_fail | input | 1 | Status failure flag |
| cnt_erase_stat | output | CNT_W | Erase-status failures |
| cnt_erase_conf | output | CNT_W | Confirmed erase failures |
| cnt_prog_fail | output | CNT_W | Program-status failures |
| cnt_mismatch | output | CNT_W | Verify byte mismatches |
| cnt_cycles | output | CNT_W | Completed passes |

## Verification
Two things fall in the same cycle: the compare of the very last read byte of a block and the end-of-block decision that it belongs to. For confirm reads, this means the block-level "any byte bad" verdict has to include a byte that arrives in the same cycle as the verdict itself. The bench provokes this with a stuck byte at the final byte of the final page. It also places a verify corruption at that same position on another block. It judges the result by the exact confirmed-erase and mismatch counts. Saturation of a counter coinciding with further increments is provoked by corrupting every read of a 32-byte verify. That value must stop at all-ones.

// File: rtl/wear_pkg.sv
`timescale 1ns/1ps
package wear_pkg;
    typedef enum logic [1:0] {
        OP_ERASE   = 2'd0,
        OP_PROGRAM = 2'd1,
        OP_READ    = 2'd2,
        OP_STATUS  = 2'd3
    } flash_op_e;

    typedef enum logic [2:0] {
        PH_ERASE   = 3'd0,
        PH_PROG    = 3'd1,
        PH_DISTURB = 3'd2,
        PH_VERIFY  = 3'd3,
        PH_CONFIRM = 3'd4,
        PH_END     = 3'd5
    } phase_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PHASE, S_CMD, S_WDATA, S_STAT_CMD,
        S_STAT_WAIT, S_RDATA, S_NEXT_BLK, S_DONE
    } seq_state_e;

    localparam int NUM_CNT   = 5;
    localparam int CI_ESTAT  = 0;
    localparam int CI_ECONF  = 1;
    localparam int CI_PFAIL  = 2;
    localparam int CI_MISM   = 3;
    localparam int CI_CYCLES = 4;

    function automatic phase_e next_phase(input phase_e p);
        unique case (p)
            PH_ERASE:   next_phase = PH_PROG;
            PH_PROG:    next_phase = PH_DISTURB;
            PH_DISTURB: next_phase = PH_VERIFY;
            PH_CONFIRM: next_phase = PH_PROG;
            default:    next_phase = PH_END;
        endcase
    endfunction
endpackage

// File: rtl/wear_pattern.sv
`timescale 1ns/1ps
module wear_pattern #(
    parameter int              LFSR_W = 32,
    parameter logic [LFSR_W-1:0] TAPS = 32'h8020_0003,
    parameter int              DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              rand_mode,
    input  logic [LFSR_W-1:0] seed,
    input  logic [DATA_W-1:0] fixed_byte,
    output logic [DATA_W-1:0] pat
);
    logic [LFSR_W-1:0] lfsr;
    logic [LFSR_W-1:0] lfsr_next;

    always_comb begin
        lfsr_next = lfsr >> 1;
        if (lfsr[0]) lfsr_next = lfsr_next ^ TAPS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lfsr <= LFSR_W'(1);
        else if (load)
            lfsr <= (seed == '0) ? LFSR_W'(1) : seed;
        else if (step)
            lfsr <= lfsr_next;
    end

    assign pat = rand_mode ? lfsr[DATA_W-1:0] : fixed_byte;

    // R10
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);
    // R10
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(lfsr));
endmodule

// File: rtl/wear_counters.sv
`timescale 1ns/1ps
module wear_counters #(
    parameter int N = 5,
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [N-1:0]        inc,
    output logic [N-1:0][W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = '1;

    for (genvar g = 0; g < N; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                count[g] <= '0;
            else if (clear)
                count[g] <= '0;
            else if (inc[g] && count[g] != CNT_MAX)
                count[g] <= count[g] + 1'b1;
        end

        // R11
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear && count[g] == CNT_MAX) |=> count[g] == CNT_MAX);
        // R11
        step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> (count[g] == $past(count[g]) || count[g] == $past(count[g]) + 1'b1));
    end
endmodule

// File: rtl/wear_cycler.sv
`timescale 1ns/1ps
module wear_cycler
    import wear_pkg::*;
#(
    parameter int          BLK_W      = 10,
    parameter int          PAGES      = 64,
    parameter int          PAGE_BYTES = 2048,
    parameter int          REP_W      = 32,
    parameter int          CNT_W      = 32,
    parameter int          SEED_W     = 32,
    parameter logic [7:0]  ERASED     = 8'hFF,
    localparam int         PAGE_W     = $clog2(PAGES),
    localparam int         BYTE_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  cfg_first_blk,
    input  logic [BLK_W-1:0]  cfg_last_blk,
    input  logic [REP_W-1:0]  cfg_repeat,
    input  logic [3:0]        cfg_ops,
    input  logic              cfg_rand,
    input  logic [SEED_W-1:0] cfg_seed,
    input  logic [7:0]        cfg_fixed,
    output logic              busy,
    output logic              done,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [BLK_W-1:0]  cmd_blk,
    output logic [PAGE_W-1:0] cmd_page,
    output logic              wd_valid,
    input  logic              wd_ready,
    output logic [7:0]        wd_data,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    input  logic              st_valid,
    input  logic              st_fail,
    output logic [CNT_W-1:0]  cnt_erase_stat,
    output logic [CNT_W-1:0]  cnt_erase_conf,
    output logic [CNT_W-1:0]  cnt_prog_fail,
    output logic [CNT_W-1:0]  cnt_mismatch,
    output logic [CNT_W-1:0]  cnt_cycles
);
    seq_state_e        state, state_n;
    phase_e            phase;
    logic [BLK_W-1:0]  blk, r_first, r_last;
    logic [PAGE_W-1:0] page;
    logic [BYTE_W-1:0] byte_idx;
    logic [REP_W-1:0]  pass_cnt, r_repeat;
    logic [3:0]        r_ops;
    logic              r_rand;
    logic [SEED_W-1:0] r_seed;
    logic [7:0]        r_fixed;
    logic              conf_bad;

    logic              start_ok, empty_run, phase_en;
    logic              page_last, byte_last, blk_last, pass_last;
    logic              cmd_fire, wd_fire, rd_beat;
    logic              pat_load, pat_step;
    logic [7:0]        pat;
    logic [NUM_CNT-1:0]            cnt_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;

    assign start_ok  = (state == S_IDLE) && start;
    assign empty_run = (cfg_repeat == '0) || (cfg_first_blk > cfg_last_blk);
    assign phase_en  = (phase inside {PH_ERASE, PH_PROG, PH_DISTURB, PH_VERIFY})
                       && r_ops[phase[1:0]];
    assign page_last = (page == PAGE_W'(PAGES - 1));
    assign byte_last = (byte_idx == BYTE_W'(PAGE_BYTES - 1));
    assign blk_last  = (blk == r_last);
    assign pass_last = (pass_cnt == r_repeat - REP_W'(1));
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign wd_fire   = wd_valid && wd_ready;
    assign rd_beat   = (state == S_RDATA) && rd_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:      if (start) state_n = empty_run ? S_DONE : S_PHASE;
            S_PHASE:     if (phase == PH_END) state_n = S_NEXT_BLK;
                         else if (phase_en)   state_n = S_CMD;
            S_CMD:       if (cmd_fire) begin
                             if (phase == PH_ERASE)     state_n = S_STAT_CMD;
                             else if (phase == PH_PROG) state_n = S_WDATA;
                             else                       state_n = S_RDATA;
                         end
            S_WDATA:     if (wd_fire && byte_last) state_n = S_STAT_CMD;
            S_STAT_CMD:  if (cmd_fire) state_n = S_STAT_WAIT;
            S_STAT_WAIT: if (st_valid) begin
                             if (phase == PH_ERASE) state_n = st_fail ? S_CMD : S_PHASE;
                             else                   state_n = page_last ? S_PHASE : S_CMD;
                         end
            S_RDATA:     if (rd_valid && byte_last) state_n = page_last ? S_PHASE : S_CMD;
            S_NEXT_BLK:  state_n = (blk_last && pass_last) ? S_DONE : S_PHASE;
            S_DONE:      state_n = S_IDLE;
            default:     state_n = S_IDLE;
        endcase
    end

    // Datapath registers (configuration, position, confirm flag)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_ERASE;
            blk      <= '0;
            r_first  <= '0;
            r_last   <= '0;
            page     <= '0;
            byte_idx <= '0;
            pass_cnt <= '0;
            r_repeat <= '0;
            r_ops    <= '0;
            r_rand   <= 1'b0;
            r_seed   <= '0;
            r_fixed  <= '0;
            conf_bad <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    r_first  <= cfg_first_blk;
                    r_last   <= cfg_last_blk;
                    r_repeat <= cfg_repeat;
                    r_ops    <= cfg_ops;
                    r_rand   <= cfg_rand;
                    r_seed   <= cfg_seed;
                    r_fixed  <= cfg_fixed;
                    blk      <= cfg_first_blk;
                    pass_cnt <= '0;
                    phase    <= PH_ERASE;
                end
                S_PHASE: begin
                    page     <= '0;
                    conf_bad <= 1'b0;
                    if (!phase_en && phase != PH_END) phase <= next_phase(phase);
                end
                S_CMD: if (cmd_fire) byte_idx <= '0;
                S_WDATA: if (wd_fire) byte_idx <= byte_idx + 1'b1;
                S_STAT_WAIT: if (st_valid) begin
                    if (phase == PH_ERASE) begin
                        phase    <= st_fail ? PH_CONFIRM : PH_PROG;
                        page     <= '0;
                        conf_bad <= 1'b0;
                    end else if (page_last) begin
                        phase <= next_phase(phase);
                    end else begin
                        page <= page + 1'b1;
                    end
                end
                S_RDATA: if (rd_valid) begin
                    byte_idx <= byte_idx + 1'b1;
                    if (phase == PH_CONFIRM && rd_data != ERASED) conf_bad <= 1'b1;
                    if (byte_last) begin
                        if (page_last) phase <= next_phase(phase);
                        else           page  <= page + 1'b1;
                    end
                end
                S_NEXT_BLK: begin
                    phase <= PH_ERASE;
                    if (blk_last) begin
                        blk      <= r_first;
                        pass_cnt <= pass_cnt + 1'b1;
                    end else begin
                        blk <= blk + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != S_IDLE) && (state != S_DONE);
        done      = (state == S_DONE);
        cmd_valid = (state == S_CMD) || (state == S_STAT_CMD);
        wd_valid  = (state == S_WDATA);
        wd_data   = pat;
        cmd_blk   = blk;
        cmd_page  = page;
        if (state == S_STAT_CMD)  cmd_op = OP_STATUS;
        else if (phase == PH_ERASE) cmd_op = OP_ERASE;
        else if (phase == PH_PROG)  cmd_op = OP_PROGRAM;
        else                        cmd_op = OP_READ;
        pat_load = (state == S_PHASE) && phase_en
                   && (phase == PH_PROG || phase == PH_VERIFY);
        pat_step = wd_fire || (rd_beat && phase == PH_VERIFY);
        cnt_inc  = '0;
        cnt_inc[CI_ESTAT]  = (state == S_STAT_WAIT) && st_valid && st_fail && phase == PH_ERASE;
        cnt_inc[CI_PFAIL]  = (state == S_STAT_WAIT) && st_valid && st_fail && phase == PH_PROG;
        cnt_inc[CI_MISM]   = rd_beat && phase == PH_VERIFY && rd_data != pat;
        cnt_inc[CI_ECONF]  = rd_beat && phase == PH_CONFIRM && byte_last && page_last
                             && (conf_bad || rd_data != ERASED);
        cnt_inc[CI_CYCLES] = (state == S_NEXT_BLK) && blk_last;
    end

    wear_pattern #(.LFSR_W(SEED_W), .DATA_W(8)) u_pattern (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pat_load),
        .step       (pat_step),
        .rand_mode  (r_rand),
        .seed       (r_seed),
        .fixed_byte (r_fixed),
        .pat        (pat)
    );

    wear_counters #(.N(NUM_CNT), .W(CNT_W)) u_counters (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_ok),
        .inc   (cnt_inc),
        .count (cnt_vec)
    );

    assign cnt_erase_stat = cnt_vec[CI_ESTAT];
    assign cnt_erase_conf = cnt_vec[CI_ECONF];
    assign cnt_prog_fail  = cnt_vec[CI_PFAIL];
    assign cnt_mismatch   = cnt_vec[CI_MISM];
    assign cnt_cycles     = cnt_vec[CI_CYCLES];

    // R12
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_op)
                                      && $stable(cmd_blk) && $stable(cmd_page));
    // R12
    wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && !wd_ready) |=> wd_valid && $stable(wd_data));
    // R3
    blk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_blk >= r_first && cmd_blk <= r_last));
    // R3
    pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pass_cnt < r_repeat);
    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    // R1
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(r_first) && $stable(r_last) && $stable(r_repeat)
                            && $stable(r_ops) && $stable(r_seed) && $stable(r_fixed))));
    // R1
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid && !wd_valid);
    // R6
    conf_le_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_erase_conf <= cnt_erase_stat);
    // R7
    wd_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_valid |-> phase == PH_PROG);
endmodule

// File: tb/wear_cycler_tb.sv
`timescale 1ns/1ps
module wear_cycler_tb;
    localparam int BLK_W = 3, PAGES = 2, PB = 4, REP_W = 8, CNT_W = 4;
    localparam int BLK_BYTES = PAGES * PB;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [BLK_W-1:0] cfg_first_blk = '0, cfg_last_blk = '0;
    logic [REP_W-1:0] cfg_repeat = '0;
    logic [3:0] cfg_ops = '0;
    logic cfg_rand = 1'b0;
    logic [31:0] cfg_seed = '0;
    logic [7:0] cfg_fixed = '0;
    logic busy, done, cmd_valid, wd_valid;
    logic cmd_ready = 1'b0, wd_ready = 1'b0, rd_valid = 1'b0, st_valid = 1'b0, st_fail = 1'b0;
    logic [1:0] cmd_op;
    logic [BLK_W-1:0] cmd_blk;
    logic [0:0] cmd_page;
    logic [7:0] wd_data, rd_data = '0;
    logic [CNT_W-1:0] cnt_erase_stat, cnt_erase_conf, cnt_prog_fail, cnt_mismatch, cnt_cycles;

    always #4 clk = ~clk;

    wear_cycler #(.BLK_W(BLK_W), .PAGES(PAGES), .PAGE_BYTES(PB), .REP_W(REP_W),
                  .CNT_W(CNT_W), .SEED_W(32), .ERASED(8'hFF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_first_blk(cfg_first_blk), .cfg_last_blk(cfg_last_blk),
        .cfg_repeat(cfg_repeat), .cfg_ops(cfg_ops), .cfg_rand(cfg_rand),
        .cfg_seed(cfg_seed), .cfg_fixed(cfg_fixed), .busy(busy), .done(done),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cmd_page(cmd_page), .wd_valid(wd_valid),
        .wd_ready(wd_ready), .wd_data(wd_data), .rd_valid(rd_valid),
        .rd_data(rd_data), .st_valid(st_valid), .st_fail(st_fail),
        .cnt_erase_stat(cnt_erase_stat), .cnt_erase_conf(cnt_erase_conf),
        .cnt_prog_fail(cnt_prog_fail), .cnt_mismatch(cnt_mismatch),
        .cnt_cycles(cnt_cycles)
    );

    int checks = 0, errors = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0] mem [BLK_BYTES * 8];
    logic [7:0] erase_fail_mask = '0, prog_fail_mask = '0;
    int stuck_blk = -1, corrupt_addr = -1;
    bit corrupt_all = 0;
    int n_erase, n_prog, n_read, n_stat, min_blk, max_blk, order_err, cur_blk, cur_rank;
    int rd_left = 0, rd_base = 0, rd_idx = 0, wr_base = 0, wr_idx = 0, rdy_cnt = 0;
    bit st_pend = 0, st_next = 0;

    task automatic clear_tally();
        n_erase = 0; n_prog = 0; n_read = 0; n_stat = 0;
        min_blk = 99; max_blk = -1; order_err = 0; cur_blk = -1; cur_rank = 0;
    endtask

    initial begin
        for (int i = 0; i < BLK_BYTES * 8; i++) mem[i] = 8'h5A;
        clear_tally();
        forever begin
            @(negedge clk);
            rd_valid = 1'b0; st_valid = 1'b0;
            if (rd_left > 0) begin
                rd_valid = 1'b1;
                rd_data = mem[rd_base + rd_idx]
                          ^ (corrupt_all ? 8'h01 : 8'h00)
                          ^ ((rd_base + rd_idx == corrupt_addr) ? 8'h10 : 8'h00);
                rd_idx++; rd_left--;
            end else if (st_pend) begin
                st_valid = 1'b1; st_fail = st_next; st_pend = 0;
            end
            rdy_cnt++;
            cmd_ready = (rdy_cnt % 3) != 0;
            wd_ready  = (rdy_cnt % 4) != 1;
            #1;
            if (cmd_valid && cmd_ready) begin
                int b, r;
                b = int'(cmd_blk);
                if (cmd_op != 2'd3) begin
                    if (b < min_blk) min_blk = b;
                    if (b > max_blk) max_blk = b;
                    r = (cmd_op == 2'd0) ? 0 : (cmd_op == 2'd1) ? 1 : 2;
                    if (b != cur_blk) begin cur_blk = b; cur_rank = r; end
                    else if (r < cur_rank) order_err++;
                    else cur_rank = r;
                end
                case (cmd_op)
                    2'd0: begin
                        n_erase++;
                        for (int i = 0; i < BLK_BYTES; i++) mem[b*BLK_BYTES + i] = 8'hFF;
                        if (b == stuck_blk) mem[b*BLK_BYTES + BLK_BYTES - 1] = 8'h7F;
                        st_next = erase_fail_mask[b];
                    end
                    2'd1: begin
                        n_prog++; wr_base = b*BLK_BYTES + int'(cmd_page)*PB; wr_idx = 0;
                        st_next = prog_fail_mask[b];
                    end
                    2'd2: begin
                        n_read++; rd_left = PB; rd_idx = 0;
                        rd_base = b*BLK_BYTES + int'(cmd_page)*PB;
                    end
                    default: begin n_stat++; st_pend = 1; end
                endcase
            end
            if (wd_valid && wd_ready) begin
                mem[wr_base + wr_idx] = wd_data; wr_idx++;
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] exp_byte(input logic [31:0] seed, input int n);
        logic [31:0] s;
        s = (seed == 0) ? 32'h1 : seed;
        for (int k = 0; k < n; k++) s = s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
        return s[7:0];
    endfunction

    task automatic cfg(input int first, input int last, input int rep, input logic [3:0] ops,
                       input bit rnd, input logic [31:0] seed, input logic [7:0] fixed);
        cfg_first_blk = BLK_W'(first); cfg_last_blk = BLK_W'(last);
        cfg_repeat = REP_W'(rep); cfg_ops = ops; cfg_rand = rnd;
        cfg_seed = seed; cfg_fixed = fixed;
    endtask

    task automatic wait_done(input string tag, output int cyc);
        cyc = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        chk({tag, " R1 done seen"}, done, 1);
        chk({tag, " R1 busy low with done"}, busy, 0);
        @(negedge clk);
        chk({tag, " R1 done one cycle"}, done, 0);
    endtask

    task automatic launch();
        clear_tally();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic chk_stream(input string tag, input int b, input logic [31:0] seed);
        int bad = 0;
        for (int i = 0; i < BLK_BYTES; i++) if (mem[b*BLK_BYTES + i] !== exp_byte(seed, i)) bad++;
        chk(tag, bad, 0);
    endtask

    task automatic chk_fill(input string tag, input int b, input logic [7:0] v);
        int bad = 0;
        for (int i = 0; i < BLK_BYTES; i++) if (mem[b*BLK_BYTES + i] !== v) bad++;
        chk(tag, bad, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int cyc;
        logic [7:0] snap [BLK_BYTES];
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R12 reset cmd_valid", cmd_valid, 0);
        chk("R11 reset counters", {cnt_erase_stat, cnt_erase_conf, cnt_prog_fail, cnt_mismatch, cnt_cycles}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // T1: all steps, random data, blocks 2..4, 3 passes
        cfg(2, 4, 3, 4'b1111, 1'b1, 32'hC0FF_EE11, 8'h00);
        launch();
        chk("R1 busy after start", busy, 1);
        wait_done("T1", cyc);
        chk("R5 erase count", n_erase, 9);
        chk("R7 program count", n_prog, 18);
        chk("R5 R7 status count", n_stat, 27);
        chk("R8 R9 read count", n_read, 36);
        chk("R3 min block", min_blk, 2);
        chk("R3 max block", max_blk, 4);
        chk("R4 step order", order_err, 0);
        chk("R3 pass counter", cnt_cycles, 3);
        chk("R9 no mismatch", cnt_mismatch, 0);
        chk("R8 erase stat clean", cnt_erase_stat, 0);
        for (int b = 2; b <= 4; b++) chk_stream("R10 LFSR stream per block", b, 32'hC0FF_EE11);
        chk_fill("R3 block 1 untouched", 1, 8'h5A);
        chk_fill("R3 block 5 untouched", 5, 8'h5A);

        // T2: fixed data, corruption at last byte of block 5, reconfig while busy
        cfg(5, 6, 2, 4'b1111, 1'b0, 32'h0, 8'hA5);
        corrupt_addr = 5*BLK_BYTES + BLK_BYTES - 1;
        launch();
        repeat (20) @(negedge clk);
        cfg(0, 7, 9, 4'b0001, 1'b1, 32'h1, 8'h00);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done("T2", cyc);
        chk("R9 mismatch on final byte", cnt_mismatch, 2);
        chk("R1 reconfig ignored min", min_blk, 5);
        chk("R1 reconfig ignored max", max_blk, 6);
        chk("R1 reconfig ignored passes", cnt_cycles, 2);
        chk_fill("R10 fixed pattern block 6", 6, 8'hA5);
        chk("R8 disturb reads not counted", n_read, 16);
        corrupt_addr = -1;

        // T3: erase status failures, one real stuck byte at final position
        erase_fail_mask = 8'b0000_0110; stuck_blk = 1;
        cfg(1, 2, 4, 4'b0001, 1'b0, 32'h0, 8'h00);
        launch();
        wait_done("T3", cyc);
        chk("R5 erase status failures", cnt_erase_stat, 8);
        chk("R6 confirmed failures", cnt_erase_conf, 4);
        chk("R6 confirm reads", n_read, 16);
        chk("R7 no program", n_prog, 0);
        erase_fail_mask = '0; stuck_blk = -1;

        // T4: program failures on block 0, counters cleared at start
        prog_fail_mask = 8'b0000_0001;
        cfg(0, 1, 2, 4'b0011, 1'b1, 32'h1234_5678, 8'h00);
        launch();
        wait_done("T4", cyc);
        chk("R11 cleared on start", cnt_erase_stat, 0);
        chk("R7 program failures", cnt_prog_fail, 4);
        chk("R7 status count", n_stat, 12);
        chk_stream("R10 stream block 1", 1, 32'h1234_5678);
        prog_fail_mask = '0;

        // T5: saturation, zero seed
        corrupt_all = 1;
        cfg(0, 3, 1, 4'b1010, 1'b1, 32'h0, 8'h00);
        launch();
        wait_done("T5", cyc);
        chk("R11 mismatch saturates", cnt_mismatch, 15);
        chk("R3 single pass", cnt_cycles, 1);
        chk_stream("R10 zero seed becomes one", 3, 32'h0);
        corrupt_all = 0;

        // T6: empty runs
        cfg(3, 3, 0, 4'b1111, 1'b0, 32'h0, 8'h00);
        launch();
        wait_done("T6", cyc);
        chk("R2 zero passes quick", cyc < 4, 1);
        chk("R2 zero passes no command", n_erase + n_prog + n_read + n_stat, 0);
        cfg(4, 2, 3, 4'b1111, 1'b0, 32'h0, 8'h00);
        launch();
        wait_done("T7", cyc);
        chk("R2 inverted span no command", n_erase + n_prog + n_read + n_stat, 0);
        chk("R2 inverted span no pass", cnt_cycles, 0);

        // T8: read-disturb only
        for (int i = 0; i < BLK_BYTES; i++) snap[i] = mem[3*BLK_BYTES + i];
        cfg(3, 3, 5, 4'b0100, 1'b0, 32'h0, 8'h00);
        launch();
        wait_done("T8", cyc);
        chk("R8 disturb read count", n_read, 10);
        chk("R4 disturb only no erase", n_erase + n_prog, 0);
        chk("R8 counters untouched", cnt_mismatch + cnt_erase_stat, 0);
        chk("R3 passes", cnt_cycles, 5);
        begin
            int bad = 0;
            for (int i = 0; i < BLK_BYTES; i++) if (mem[3*BLK_BYTES + i] !== snap[i]) bad++;
            chk("R8 block data unchanged", bad, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule